// File: doc/BRIEF.md
# Thermally Assisted Write Sequencer

This controller turns a single write request for a magnetic configuration bit into the timed drive pattern that such a bit needs. A cell is written by heating it, applying a write field while it is hot, and letting it cool with the field still on. The block addresses one cell out of a small array and drives three things: a one-hot heating select, a write-line enable, and a direction control. The direction control follows the request's data bit, because the polarity of the write-line current decides the stored value.

Each of the three phases has a minimum length in clock cycles, taken from duration inputs. A duration of zero is treated as one cycle. All three durations are captured when the request is accepted. One setup cycle before heating puts the direction on the line ahead of any field. After the field is removed, a one-cycle done pulse is given and the sequencer returns to idle. The logic that the stored bits configure keeps running during a write. The handshake is simple: a request is accepted only while ready is high, and there is no queue.

Top module: `wsq_seq`

## Requirements
- R1: After reset and whenever the sequencer is idle, req_ready is 1 and heat_sel, field_en, field_dir and done are all 0. req_ready is 0 in every other state.
- R2: A request is accepted at a clock edge where req_valid and req_ready are both 1. The first cycle after acceptance is a setup cycle: field_dir equals the request data, heat_sel is 0 and field_en is 0.
- R3: The heat phase follows setup. In it, heat_sel bit number req_addr is 1, all other heat_sel bits are 0, and field_en is 0. It lasts the captured heat duration in cycles.
- R4: The switch phase follows heat. In it, the same heat_sel bit stays 1 and field_en is 1. It lasts the captured switch duration in cycles.
- R5: The cool phase follows switch. In it, heat_sel is all 0 and field_en is 1. It lasts the captured cool duration in cycles.
- R6: field_dir equals the accepted data bit (1 means data 1) from setup through the end of cool. It never changes in a cycle where field_en is 1.
- R7: The cycle after cool has done = 1 with heat_sel, field_en and field_dir all 0. The next cycle is idle. done is never high for two cycles in a row.
- R8: A request presented while busy is ignored and is not queued. It does not change the running write's outputs or timing. If req_valid drops before the sequencer reaches idle, no second write starts.
- R9: The phase durations are captured at acceptance. Changing dur_heat, dur_switch or dur_cool during a write does not change that write.
- R10: A duration input of 0 gives a phase length of 1 cycle.
- R11: At most one heat_sel bit is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, able to accept a request |
| req_addr | input | ADDR_W | Index of the cell to write |
| req_data | input | 1 | Bit value to store |
| dur_heat | input | DUR_W | Heat phase length in cycles (0 is taken as 1) |
| dur_switch | input | DUR_W | Switch phase length in cycles (0 is taken as 1) |
| dur_cool | input | DUR_W | Field-cool phase length in cycles (0 is taken as 1) |
| heat_sel | output | 2**ADDR_W | One-hot heating select for the addressed cell |
| field_en | output | 1 | Write-line current enable |
| field_dir | output | 1 | Write-line current direction |
| done | output | 1 | One-cycle pulse after the field is removed |

## Verification
All outputs are decoded from the phase state and the one phase counter. A wrong state or a counter off by one therefore shows up at the ports in the same cycle. The symptom is a phase boundary one cycle early or late, heat and field overlapping in the wrong order, or done appearing out of place. The bench sweeps every combination of small durations, including zero, for both data values and several addresses. It compares each cycle of every write against a timeline worked out in the bench. This way any shift in a phase edge is caught at the cycle where it happens. Writes are also repeated with requests and duration changes injected mid-write. A captured-value or handshake error then shows as a changed phase length, a wrong select bit, or a second write that should not happen.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_HEAT   = 3'd2,
        ST_SWITCH = 3'd3,
        ST_COOL   = 3'd4,
        ST_DONE   = 3'd5
    } wsq_state_e;

    // Phase drive levels decoded from the state
    typedef struct packed {
        logic heat_on;
        logic field_on;
        logic dir_on;
        logic done;
    } wsq_drive_t;

    // Reload value for a phase counter: a zero length behaves as one cycle
    function automatic logic [31:0] wsq_reload(input logic [31:0] dur);
        return (dur == 32'd0) ? 32'd0 : dur - 32'd1;
    endfunction

endpackage

// File: rtl/wsq_phase_timer.sv
module wsq_phase_timer #(
    parameter int DUR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    output logic             expire
);
    logic [DUR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/wsq_drive_decode.sv
module wsq_drive_decode
    import wsq_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NCELL = 1 << ADDR_W
) (
    input  wsq_state_e        state,
    input  logic [ADDR_W-1:0] addr,
    input  logic              data,
    output logic [NCELL-1:0]  heat_sel,
    output logic              field_en,
    output logic              field_dir,
    output logic              done
);
    wsq_drive_t drv;

    always_comb begin
        drv = '0;
        unique case (state)
            ST_SETUP:  drv.dir_on = 1'b1;
            ST_HEAT:   begin drv.dir_on = 1'b1; drv.heat_on = 1'b1; end
            ST_SWITCH: begin drv.dir_on = 1'b1; drv.heat_on = 1'b1; drv.field_on = 1'b1; end
            ST_COOL:   begin drv.dir_on = 1'b1; drv.field_on = 1'b1; end
            ST_DONE:   drv.done = 1'b1;
            default:   drv = '0;
        endcase
    end

    for (genvar i = 0; i < NCELL; i++) begin : g_sel
        assign heat_sel[i] = drv.heat_on && (addr == ADDR_W'(i));
    end

    assign field_en  = drv.field_on;
    assign field_dir = drv.dir_on & data;
    assign done      = drv.done;
endmodule

// File: rtl/wsq_seq.sv
module wsq_seq
    import wsq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DUR_W  = 4,
    localparam int NCELL = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_data,
    input  logic [DUR_W-1:0]  dur_heat,
    input  logic [DUR_W-1:0]  dur_switch,
    input  logic [DUR_W-1:0]  dur_cool,
    output logic [NCELL-1:0]  heat_sel,
    output logic              field_en,
    output logic              field_dir,
    output logic              done
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              data;
        logic [DUR_W-1:0]  rl_heat;
        logic [DUR_W-1:0]  rl_switch;
        logic [DUR_W-1:0]  rl_cool;
    } job_t;

    wsq_state_e       state_q, state_d;
    job_t             job_q;
    logic             accept;
    logic             tmr_load;
    logic [DUR_W-1:0] tmr_val;
    logic             tmr_expire;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '0;
        end else if (accept) begin
            job_q.addr      <= req_addr;
            job_q.data      <= req_data;
            job_q.rl_heat   <= DUR_W'(wsq_reload(32'(dur_heat)));
            job_q.rl_switch <= DUR_W'(wsq_reload(32'(dur_switch)));
            job_q.rl_cool   <= DUR_W'(wsq_reload(32'(dur_cool)));
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  begin state_d = ST_HEAT; tmr_load = 1'b1; tmr_val = job_q.rl_heat; end
            ST_HEAT:   if (tmr_expire) begin
                           state_d = ST_SWITCH; tmr_load = 1'b1; tmr_val = job_q.rl_switch;
                       end
            ST_SWITCH: if (tmr_expire) begin
                           state_d = ST_COOL; tmr_load = 1'b1; tmr_val = job_q.rl_cool;
                       end
            ST_COOL:   if (tmr_expire) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    wsq_phase_timer #(.DUR_W(DUR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    wsq_drive_decode #(.ADDR_W(ADDR_W)) u_decode (
        .state     (state_q),
        .addr      (job_q.addr),
        .data      (job_q.data),
        .heat_sel  (heat_sel),
        .field_en  (field_en),
        .field_dir (field_dir),
        .done      (done)
    );
endmodule

// File: rtl/wsq_seq_chk.sv
module wsq_seq_chk #(
    parameter int NCELL = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic [NCELL-1:0] heat_sel,
    input logic             field_en,
    input logic             field_dir,
    input logic             done
);
    logic heat_any;
    assign heat_any = |heat_sel;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!heat_any && !field_en && !field_dir && !done)); // R1
    AST_HEAT_BEFORE_FIELD: assert property (@(posedge clk) disable iff (rst)
        $rose(field_en) |-> heat_any); // R4
    AST_COOL_UNDER_FIELD: assert property (@(posedge clk) disable iff (rst)
        $fell(heat_any) |-> field_en); // R5
    AST_DIR_STEADY: assert property (@(posedge clk) disable iff (rst)
        field_en |-> $stable(field_dir)); // R6
    AST_DONE_AFTER_FIELD: assert property (@(posedge clk) disable iff (rst)
        done |-> (!field_en && !heat_any && $past(field_en))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready)); // R7
    AST_ONE_HEAT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(heat_sel)); // R11
endmodule

bind wsq_seq wsq_seq_chk #(.NCELL(NCELL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .heat_sel  (heat_sel),
    .field_en  (field_en),
    .field_dir (field_dir),
    .done      (done)
);

// File: tb/wsq_seq_test.sv
module wsq_seq_test;
    localparam int AW = 3;
    localparam int DW = 4;
    localparam int NC = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_data = 1'b0;
    logic [DW-1:0] dur_heat = '0, dur_switch = '0, dur_cool = '0;
    logic [NC-1:0] heat_sel;
    logic          field_en, field_dir, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wsq_seq #(.ADDR_W(AW), .DUR_W(DW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .dur_heat(dur_heat),
        .dur_switch(dur_switch), .dur_cool(dur_cool), .heat_sel(heat_sel),
        .field_en(field_en), .field_dir(field_dir), .done(done)
    );

    task automatic check(input string req, input logic [NC-1:0] e_sel, input logic e_fen,
                         input logic e_dir, input logic e_done, input logic e_rdy);
        n_tests++;
        if (heat_sel !== e_sel || field_en !== e_fen || field_dir !== e_dir ||
            done !== e_done || req_ready !== e_rdy) begin
            n_fail++;
            $display("FAIL %s t=%0t got sel=%b fen=%b dir=%b done=%b rdy=%b exp sel=%b fen=%b dir=%b done=%b rdy=%b",
                     req, $time, heat_sel, field_en, field_dir, done, req_ready,
                     e_sel, e_fen, e_dir, e_done, e_rdy);
        end
    endtask

    // One write, checked cycle by cycle; disturb injects a busy request and new durations
    task automatic run_write(input logic [AW-1:0] a, input logic d,
                             input int h, input int s, input int c, input bit disturb);
        int he, se, ce, kdone;
        logic [NC-1:0] oh;
        he = (h == 0) ? 1 : h;   // R10
        se = (s == 0) ? 1 : s;
        ce = (c == 0) ? 1 : c;
        kdone = 2 + he + se + ce;
        oh = NC'(1) << a;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        dur_heat = DW'(h); dur_switch = DW'(s); dur_cool = DW'(c);
        @(posedge clk);
        for (int k = 1; k <= kdone + 2; k++) begin
            @(negedge clk);
            if (k == 1) check("R2 setup", '0, 1'b0, d, 1'b0, 1'b0);
            else if (k <= 1 + he) check(disturb ? "R8/R9 heat" : "R3 heat", oh, 1'b0, d, 1'b0, 1'b0);
            else if (k <= 1 + he + se) check(disturb ? "R8/R9 switch" : "R4 switch", oh, 1'b1, d, 1'b0, 1'b0);
            else if (k <= 1 + he + se + ce) check(disturb ? "R8/R9 cool" : "R5/R6 cool", '0, 1'b1, d, 1'b0, 1'b0);
            else if (k == kdone) check("R7 done", '0, 1'b0, 1'b0, 1'b1, 1'b0);
            else check("R8 idle after write", '0, 1'b0, 1'b0, 1'b0, 1'b1);
            if (k == 1) begin
                req_valid = disturb; req_addr = ~a; req_data = ~d;
                if (disturb) begin dur_heat = 4'd9; dur_switch = 4'd9; dur_cool = 4'd9; end
            end
            if (k == kdone) req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", '0, 1'b0, 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle", '0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int h = 0; h < 4; h++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 2; d++)
                        run_write(AW'(h * 3 + s * 5 + c + d * 4), d[0], h, s, c, 1'b0);
        for (int a = 0; a < NC; a++)
            run_write(AW'(a), a[0], 1 + a % 3, 2, 1 + a % 2, 1'b1);
        run_write(AW'(NC - 1), 1'b1, 15, 15, 15, 1'b0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule